// File: doc/BRIEF.md
# Multi-Function Timer Interrupt Controller

This block keeps time for a small processor subsystem. A free-running counter advances once for every prescaled tick. When it wraps from all ones back to zero it raises an overflow flag. Alongside it, a binary divider chain is clocked by the same tick. Software picks one of four chain stages with a two-bit rate field. Each rising edge of the chosen stage raises a periodic (real-time) flag.

Software sees one control/status byte and a read-only view of the counter. The two flags cannot be written. Each flag is cleared only by writing a one to its own acknowledge bit, and both acknowledge bits always read back as zero. Each flag has an enable bit. The single interrupt request is active while any enabled flag is set.

Top module: `mft_timer`

## Requirements
- R1: The counter (CNT_W bits) increments on every clock edge at which `tick` is high, holds otherwise, and wraps to zero after all ones. It reads at address 1, zero-extended to 8 bits. Writes to address 1 have no effect.
- R2: The overflow flag (control bit 7) sets at the edge where the counter wraps from all ones to zero.
- R3: With rate field s (control bits 1:0), the periodic flag (control bit 6) sets every 2^(TAP_BASE+s) ticks. Its first set comes after 2^(TAP_BASE+s-1) ticks counted from reset.
- R4: Writing to control bits 7 and 6 never changes either flag.
- R5: Writing a one to control bit 3 clears the overflow flag. Writing a one to control bit 2 clears the periodic flag. Writing zero to either bit leaves its flag unchanged.
- R6: Control bits 3 and 2 always read as zero.
- R7: If a flag's set event and its acknowledge write fall in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when the overflow flag and its enable (control bit 5) are both set, or the periodic flag and its enable (control bit 4) are both set. It follows the registered state in the same cycle.
- R9: Reset clears both flags, both enables, the rate field, the counter, the divider chain and the read data.
- R10: A read strobe at an edge loads `rd_data` with the addressed register, and the value is visible after that edge. Without a strobe, `rd_data` holds.
- R11: Control bits 5, 4 and 1:0 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled count enable |
| we | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address (0 control/status, 1 counter) |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Combined timer interrupt request |

## Verification
The bench builds the block with a 4-bit counter and TAP_BASE of 2. The counter therefore wraps every 16 ticks, and the four rate settings give periods of 4, 8, 16 and 32 ticks. All four rates, repeated overflows, and a wrap of the divider chain itself can then be reached within a few hundred cycles. This also makes it cheap to line up a set event with an acknowledge write in the same cycle.

// File: rtl/mft_pkg.sv
package mft_pkg;
    localparam int DATA_W = 8;

    // register addresses
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_COUNT = 1;

    // control/status bit positions
    localparam int B_OVF_FLAG = 7;
    localparam int B_RTI_FLAG = 6;
    localparam int B_OVF_EN   = 5;
    localparam int B_RTI_EN   = 4;
    localparam int B_OVF_ACK  = 3;
    localparam int B_RTI_ACK  = 2;
    localparam int B_RSEL_HI  = 1;
    localparam int B_RSEL_LO  = 0;
    localparam int RSEL_FIELD_W = B_RSEL_HI - B_RSEL_LO + 1;
endpackage

// File: rtl/mft_chain.sv
module mft_chain #(
    parameter int CNT_W   = 8,
    parameter int CHAIN_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    output logic [CNT_W-1:0]   cnt,
    output logic [CHAIN_W-1:0] chain,
    output logic               ovf_evt
);
    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [CHAIN_W-1:0] chain;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        ovf_evt = 1'b0;
        if (tick) begin
            st_d.cnt   = st_q.cnt + CNT_W'(1);
            st_d.chain = st_q.chain + CHAIN_W'(1);
            ovf_evt    = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign chain = st_q.chain;
endmodule

// File: rtl/mft_rti_tap.sv
module mft_rti_tap #(
    parameter int TAP_BASE = 10,
    parameter int TAP_N    = 4,
    parameter int CHAIN_W  = TAP_BASE + TAP_N - 1,
    parameter int RSEL_W   = $clog2(TAP_N)
) (
    input  logic               tick,
    input  logic [CHAIN_W-1:0] chain,
    input  logic [RSEL_W-1:0]  rsel,
    output logic               rti_evt
);
    logic [TAP_N-1:0] tap_evt;

    // Stage i is chain bit k = TAP_BASE-1+i. It rises when the increment
    // carries into it: bit k low and every bit below it high.
    for (genvar i = 0; i < TAP_N; i++) begin : g_tap
        localparam int K = TAP_BASE - 1 + i;
        assign tap_evt[i] = tick & ~chain[K] & (&chain[K-1:0]);
    end

    always_comb begin
        rti_evt = tap_evt[rsel];
    end
endmodule

// File: rtl/mft_regs.sv
module mft_regs #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 2,
    parameter int RSEL_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [mft_pkg::DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]           cnt,
    input  logic                       ovf_evt,
    input  logic                       rti_evt,
    output logic [RSEL_W-1:0]          rsel,
    output logic                       ovf_flag,
    output logic                       rti_flag,
    output logic                       ovf_en,
    output logic                       rti_en,
    output logic [mft_pkg::DATA_W-1:0] rd_data,
    output logic                       irq
);
    import mft_pkg::*;

    typedef struct packed {
        logic              ovf_flag;
        logic              rti_flag;
        logic              ovf_en;
        logic              rti_en;
        logic [RSEL_W-1:0] rsel;
        logic [DATA_W-1:0] rd_data;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic              wr_ctrl;
    logic              sel_ctrl;
    logic              sel_count;
    logic [DATA_W-1:0] ctrl_view;
    logic [DATA_W-1:0] read_mux;
    logic              unused_wbits;

    assign unused_wbits = ^{wdata[B_OVF_FLAG], wdata[B_RTI_FLAG]};

    assign sel_ctrl  = (addr == ADDR_W'(ADDR_CTRL));
    assign sel_count = (addr == ADDR_W'(ADDR_COUNT));
    assign wr_ctrl   = we & sel_ctrl;

    always_comb begin
        ctrl_view = '0;
        ctrl_view[B_OVF_FLAG] = st_q.ovf_flag;
        ctrl_view[B_RTI_FLAG] = st_q.rti_flag;
        ctrl_view[B_OVF_EN]   = st_q.ovf_en;
        ctrl_view[B_RTI_EN]   = st_q.rti_en;
        ctrl_view[B_RSEL_HI:B_RSEL_LO] = RSEL_FIELD_W'(st_q.rsel);
    end

    always_comb begin
        if (sel_ctrl) begin
            read_mux = ctrl_view;
        end else if (sel_count) begin
            read_mux = DATA_W'(cnt);
        end else begin
            read_mux = '0;
        end
    end

    always_comb begin
        st_d = st_q;

        // flags: a set event wins over a same-cycle acknowledge
        if (ovf_evt) begin
            st_d.ovf_flag = 1'b1;
        end else if (wr_ctrl && wdata[B_OVF_ACK]) begin
            st_d.ovf_flag = 1'b0;
        end

        if (rti_evt) begin
            st_d.rti_flag = 1'b1;
        end else if (wr_ctrl && wdata[B_RTI_ACK]) begin
            st_d.rti_flag = 1'b0;
        end

        if (wr_ctrl) begin
            st_d.ovf_en = wdata[B_OVF_EN];
            st_d.rti_en = wdata[B_RTI_EN];
            st_d.rsel   = RSEL_W'(wdata[B_RSEL_HI:B_RSEL_LO]);
        end

        if (rd_en) begin
            st_d.rd_data = read_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsel     = st_q.rsel;
    assign ovf_flag = st_q.ovf_flag;
    assign rti_flag = st_q.rti_flag;
    assign ovf_en   = st_q.ovf_en;
    assign rti_en   = st_q.rti_en;
    assign rd_data  = st_q.rd_data;
    assign irq      = (st_q.ovf_flag & st_q.ovf_en) | (st_q.rti_flag & st_q.rti_en);
endmodule

// File: rtl/mft_timer.sv
module mft_timer #(
    parameter int CNT_W    = 8,
    parameter int TAP_BASE = 10,
    parameter int TAP_N    = 4,
    parameter int ADDR_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       we,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [mft_pkg::DATA_W-1:0] wdata,
    output logic [mft_pkg::DATA_W-1:0] rd_data,
    output logic                       irq
);
    localparam int CHAIN_W = TAP_BASE + TAP_N - 1;
    localparam int RSEL_W  = $clog2(TAP_N);

    logic [CNT_W-1:0]   cnt;
    logic [CHAIN_W-1:0] chain;
    logic [RSEL_W-1:0]  rsel;
    logic               ovf_evt;
    logic               rti_evt;
    logic               ovf_flag;
    logic               rti_flag;
    logic               ovf_en;
    logic               rti_en;

    mft_chain #(
        .CNT_W   (CNT_W),
        .CHAIN_W (CHAIN_W)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt     (cnt),
        .chain   (chain),
        .ovf_evt (ovf_evt)
    );

    mft_rti_tap #(
        .TAP_BASE (TAP_BASE),
        .TAP_N    (TAP_N),
        .CHAIN_W  (CHAIN_W),
        .RSEL_W   (RSEL_W)
    ) u_tap (
        .tick    (tick),
        .chain   (chain),
        .rsel    (rsel),
        .rti_evt (rti_evt)
    );

    mft_regs #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .RSEL_W (RSEL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (we),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .cnt      (cnt),
        .ovf_evt  (ovf_evt),
        .rti_evt  (rti_evt),
        .rsel     (rsel),
        .ovf_flag (ovf_flag),
        .rti_flag (rti_flag),
        .ovf_en   (ovf_en),
        .rti_en   (rti_en),
        .rd_data  (rd_data),
        .irq      (irq)
    );
endmodule

// File: rtl/mft_timer_chk.sv
module mft_timer_chk #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick,
    input logic                       we,
    input logic                       rd_en,
    input logic [ADDR_W-1:0]          addr,
    input logic [mft_pkg::DATA_W-1:0] wdata,
    input logic [mft_pkg::DATA_W-1:0] rd_data,
    input logic                       irq,
    input logic [CNT_W-1:0]           cnt,
    input logic                       ovf_evt,
    input logic                       rti_evt,
    input logic                       ovf_flag,
    input logic                       rti_flag,
    input logic                       ovf_en,
    input logic                       rti_en
);
    import mft_pkg::*;

    logic wr_ctrl;
    assign wr_ctrl = we && (addr == ADDR_W'(ADDR_CTRL));

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt == $past(cnt) + CNT_W'(1));

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    // R2
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> cnt == '0);

    // R3
    rti_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rti_flag) |-> $past(rti_evt));

    // R4
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_evt && !(wr_ctrl && wdata[B_OVF_ACK])) |=> $stable(ovf_flag));

    // R4
    rti_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rti_evt && !(wr_ctrl && wdata[B_RTI_ACK])) |=> $stable(rti_flag));

    // R5
    ovf_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[B_OVF_ACK] && !ovf_evt) |=> !ovf_flag);

    // R5
    rti_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[B_RTI_ACK] && !rti_evt) |=> !rti_flag);

    // R6
    ack_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(ADDR_CTRL)) |=> rd_data[B_OVF_ACK:B_RTI_ACK] == 2'b00);

    // R7
    ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);

    // R7
    rti_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rti_evt |=> rti_flag);

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag || rti_flag) && (ovf_en || rti_en));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind mft_timer mft_timer_chk #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .we       (we),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rd_data  (rd_data),
    .irq      (irq),
    .cnt      (cnt),
    .ovf_evt  (ovf_evt),
    .rti_evt  (rti_evt),
    .ovf_flag (ovf_flag),
    .rti_flag (rti_flag),
    .ovf_en   (ovf_en),
    .rti_en   (rti_en)
);

// File: tb/tb_mft_timer.sv
`timescale 1ns/1ps
module tb_mft_timer;
    localparam int CNT_W    = 4;
    localparam int TAP_BASE = 2;
    localparam int TAP_N    = 4;
    localparam int ADDR_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              we = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rd_data;
    logic              irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mft_timer #(
        .CNT_W    (CNT_W),
        .TAP_BASE (TAP_BASE),
        .TAP_N    (TAP_N),
        .ADDR_W   (ADDR_W)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .we      (we),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .irq     (irq)
    );

    // ticks to apply, optional control write, then expected control, counter, irq
    typedef struct packed {
        logic [7:0] ticks;
        logic       wr;
        logic [7:0] wd;
        logic [7:0] exp_ctrl;
        logic [7:0] exp_cnt;
        logic       exp_irq;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VEC [NVEC] = '{
        '{8'd1,  1'b0, 8'h00, 8'h00, 8'd1,  1'b0}, // R3 rate 0 not yet
        '{8'd1,  1'b0, 8'h00, 8'h40, 8'd2,  1'b0}, // R3 first rate-0 event
        '{8'd0,  1'b1, 8'hD0, 8'h50, 8'd2,  1'b1}, // R4 flag bits ignored, R8
        '{8'd0,  1'b1, 8'h14, 8'h10, 8'd2,  1'b0}, // R5 periodic ack
        '{8'd3,  1'b0, 8'h00, 8'h10, 8'd5,  1'b0}, // R3 between events
        '{8'd1,  1'b0, 8'h00, 8'h50, 8'd6,  1'b1}, // R3 period 4
        '{8'd0,  1'b1, 8'h11, 8'h51, 8'd6,  1'b1}, // R11 rate 1, flag kept
        '{8'd0,  1'b1, 8'h05, 8'h01, 8'd6,  1'b0}, // R5 ack with enable off
        '{8'd2,  1'b0, 8'h00, 8'h01, 8'd8,  1'b0}, // R3 rate 1 quiet
        '{8'd4,  1'b0, 8'h00, 8'h41, 8'd12, 1'b0}, // R3 rate 1 event, R8 masked
        '{8'd0,  1'b1, 8'h21, 8'h61, 8'd12, 1'b0}, // R11 overflow enable
        '{8'd4,  1'b0, 8'h00, 8'hE1, 8'd0,  1'b1}, // R2 wrap
        '{8'd0,  1'b1, 8'h29, 8'h61, 8'd0,  1'b0}, // R5 overflow ack
        '{8'd0,  1'b1, 8'h36, 8'h32, 8'd0,  1'b0}, // R11 rate 2, both enables
        '{8'd8,  1'b0, 8'h00, 8'h72, 8'd8,  1'b1}, // R3 rate 2 event
        '{8'd0,  1'b1, 8'h3B, 8'h73, 8'd8,  1'b1}, // R5 ack on clear flag
        '{8'd0,  1'b1, 8'h37, 8'h33, 8'd8,  1'b0}, // R5 periodic ack
        '{8'd8,  1'b0, 8'h00, 8'hB3, 8'd0,  1'b1}, // R2 second wrap
        '{8'd16, 1'b0, 8'h00, 8'hF3, 8'd0,  1'b1}  // R3 rate 3 event
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic step_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic tk);
        we = 1'b1; addr = a; wdata = d; tick = tk;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; tick = 1'b0; wdata = '0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        do_reset();

        // R9 reset state
        check("R9 rd_data after reset", rd_data, 8'h00);
        check("R8 irq after reset", {7'd0, irq}, 8'h00);
        do_read(2'd0, v);
        check("R9 R6 control after reset", v, 8'h00);
        do_read(2'd1, v);
        check("R9 counter after reset", v, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            step_ticks(int'(VEC[i].ticks));
            if (VEC[i].wr) do_write(2'd0, VEC[i].wd, 1'b0);
            do_read(2'd0, v);
            check($sformatf("R3 R4 R5 R6 R11 ctrl vec %0d", i), v, VEC[i].exp_ctrl);
            do_read(2'd1, v);
            check($sformatf("R1 R2 counter vec %0d", i), v, VEC[i].exp_cnt);
            check($sformatf("R8 irq vec %0d", i), {7'd0, irq}, {7'd0, VEC[i].exp_irq});
        end

        // R9 reset from a busy state
        do_reset();
        check("R9 rd_data cleared", rd_data, 8'h00);
        check("R9 irq cleared", {7'd0, irq}, 8'h00);
        do_read(2'd0, v);
        check("R9 control cleared", v, 8'h00);

        // R7 periodic event and its ack in the same cycle
        do_write(2'd0, 8'h10, 1'b0);
        step_ticks(1);
        do_write(2'd0, 8'h14, 1'b1);
        do_read(2'd0, v);
        check("R7 periodic set beats ack", v, 8'h50);
        check("R7 R8 irq with periodic set", {7'd0, irq}, 8'h01);

        // R7 overflow event and its ack in the same cycle
        do_reset();
        do_write(2'd0, 8'h20, 1'b0);
        step_ticks(15);
        do_write(2'd0, 8'h28, 1'b1);
        do_read(2'd0, v);
        check("R7 overflow set beats ack", v, 8'hE0);
        check("R7 R8 irq with overflow set", {7'd0, irq}, 8'h01);

        // R1 counter ignores writes
        do_write(2'd1, 8'hFF, 1'b0);
        do_read(2'd1, v);
        check("R1 counter write ignored", v, 8'h00);

        // R10 read data holds without a strobe
        step_ticks(3);
        check("R10 rd_data holds", rd_data, 8'h00);
        do_read(2'd1, v);
        check("R10 R1 counter read after ticks", v, 8'h03);

        // R5 zero in both ack bits keeps the flags
        do_write(2'd0, 8'h20, 1'b0);
        do_read(2'd0, v);
        check("R5 zero ack keeps flags", v, 8'hE0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule